// File: doc/BRIEF.md
# Management-Bus Clock-Low Timeout Monitor

This block observes the clock and data lines of a shared two-wire management bus and polices how long the clock is held low. It has three checks. The first is a bound on any single continuous low phase. The second is a budget for cumulative stretching across a whole message, counted from START to STOP and charged to the responding device. The third is a smaller budget for stretching inside each byte, charged to the initiating device. A low phase is allowed a fixed grace length. Only the low cycles beyond that grace count as extension.

When any limit is crossed, the block sets a sticky flag and emits a one-cycle reset pulse to the bus interface logic it guards. It then stops charging extension until the next START, which abandons the transaction in progress. All limits are parameters counted in system-clock cycles. The defaults assume a 125 MHz clock: 35 ms timeout, 25 ms message budget, 10 ms byte budget and 5 us grace. The block moves no data stream, so every pin is a plain level or pulse with no handshake.

Top module: `smbus_lowtime_mon`

## Requirements
- R1: After reset all three flags and `port_rst` are 0, and the line synchronizer holds both lines as idle-high, so no START or STOP is seen from reset.
- R2: When the synchronized clock line has been low for `TOUT_CYC` consecutive samples, `tout_flag` is set. A low phase of `TOUT_CYC-1` samples does not set it.
- R3: The continuous-low count restarts whenever the clock line is sampled high. Two low phases, each shorter than `TOUT_CYC` and separated by a high phase, never time out.
- R4: In each low phase, the first `GRACE_CYC` low samples are free. Every later low sample inside a message adds one unit of extension.
- R5: Extension accumulated between a START and the next STOP reaching `SEXT_CYC` sets `slv_ext_flag`. The message total restarts at every START.
- R6: Extension accumulated within one byte reaching `MEXT_CYC` sets `mst_ext_flag`. A byte is a run of 9 clock rising edges after START. The byte total restarts at START, at STOP and at each 9th rising edge.
- R7: Each violation cycle produces exactly one `port_rst` pulse, one clock wide, on the same edge as the flag it sets.
- R8: After any violation, no further extension is charged until the next START. The timeout check stays active.
- R9: The flags stay set until `flag_clr` is asserted. A cycle with `flag_clr` high and no new violation clears them.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The timeout applies even outside a message, while extension is charged only inside one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_raw | input | 1 | Filtered bus clock line, asynchronous |
| sda_raw | input | 1 | Filtered bus data line, asynchronous |
| flag_clr | input | 1 | Clears the sticky flags |
| tout_flag | output | 1 | Sticky: continuous low limit reached |
| slv_ext_flag | output | 1 | Sticky: per-message extension budget spent |
| mst_ext_flag | output | 1 | Sticky: per-byte extension budget spent |
| port_rst | output | 1 | One-cycle reset pulse to the guarded interface |

## Verification
The hardest situation to reach is a single low phase that crosses two limits in order. An example is the message budget running out first and the continuous-low limit being reached later in the same phase. This must give two separate pulses, and the abandoned message must charge nothing more. Random messages reach this by mixing many short phases with occasional phases longer than the timeout. A bench model computes, phase by phase, the low sample at which each limit would fire. It also handles byte boundaries every nine phases. Directed messages pin the exact limit, limit minus one, and three separate bytes that each stay under the byte budget while together spending the message budget.

// File: rtl/smbus_mon_pkg.sv
package smbus_mon_pkg;
  // Decoded bus conditions, one sample wide
  typedef struct packed {
    logic rise;
    logic start;
    logic stop;
  } bus_ev_t;

  localparam int unsigned BITS_PER_BYTE = 9;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events
  import smbus_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    s_scl,
  input  logic    s_sda,
  output bus_ev_t ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= s_scl;
      sda_q <= s_sda;
    end
  end

  always_comb begin
    ev.rise  = s_scl & ~scl_q;
    ev.start = s_scl & scl_q & sda_q & ~s_sda;
    ev.stop  = s_scl & scl_q & ~sda_q & s_sda;
  end
endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer #(
  parameter int unsigned TOUT_CYC  = 4_375_000,
  parameter int unsigned GRACE_CYC = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_low,
  output logic timeout_evt,
  output logic excess
);
  localparam int unsigned CW = $clog2(TOUT_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !scl_low)            cnt <= '0;
    else if (cnt != CW'(TOUT_CYC))  cnt <= cnt + 1'b1;
  end

  assign timeout_evt = scl_low && (cnt == CW'(TOUT_CYC - 1));
  assign excess      = scl_low && (cnt >= CW'(GRACE_CYC));
endmodule

// File: rtl/smb_ext_budget.sv
module smb_ext_budget #(
  parameter int unsigned LIMIT = 1_250_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int unsigned AW = $clog2(LIMIT + 1);
  logic [AW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr)                       acc <= '0;
    else if (inc && acc != AW'(LIMIT))    acc <= acc + 1'b1;
  end

  assign hit = inc && (acc == AW'(LIMIT - 1));
endmodule

// File: rtl/smbus_lowtime_mon.sv
module smbus_lowtime_mon
  import smbus_mon_pkg::*;
#(
  parameter int unsigned TOUT_CYC  = 4_375_000,
  parameter int unsigned SEXT_CYC  = 3_125_000,
  parameter int unsigned MEXT_CYC  = 1_250_000,
  parameter int unsigned GRACE_CYC = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  input  logic flag_clr,
  output logic tout_flag,
  output logic slv_ext_flag,
  output logic mst_ext_flag,
  output logic port_rst
);
  localparam int unsigned BW = $clog2(BITS_PER_BYTE);

  logic [1:0] lines_s;
  bus_ev_t    ev;
  logic       s_scl, s_sda;
  logic       t_evt, excess, s_evt, m_evt, any_evt;
  logic       in_msg, byte_end, charge;
  logic [BW-1:0] bit_cnt;

  smb_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_raw, sda_raw}), .q(lines_s)
  );
  assign s_scl = lines_s[1];
  assign s_sda = lines_s[0];

  smb_bus_events u_ev (
    .clk(clk), .rst(rst), .s_scl(s_scl), .s_sda(s_sda), .ev(ev)
  );

  smb_low_timer #(.TOUT_CYC(TOUT_CYC), .GRACE_CYC(GRACE_CYC)) u_low (
    .clk(clk), .rst(rst), .scl_low(~s_scl),
    .timeout_evt(t_evt), .excess(excess)
  );

  assign charge = in_msg & excess;

  // message-wide and per-byte budgets share one accumulator design
  smb_ext_budget #(.LIMIT(SEXT_CYC)) u_msg (
    .clk(clk), .rst(rst), .clr(ev.start), .inc(charge), .hit(s_evt)
  );
  smb_ext_budget #(.LIMIT(MEXT_CYC)) u_byte (
    .clk(clk), .rst(rst), .clr(ev.start | ev.stop | byte_end),
    .inc(charge), .hit(m_evt)
  );

  assign any_evt  = t_evt | s_evt | m_evt;
  assign byte_end = in_msg & ev.rise & (bit_cnt == BW'(BITS_PER_BYTE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_msg  <= 1'b0;
      bit_cnt <= '0;
    end else begin
      if (ev.start)                 in_msg <= 1'b1;
      else if (ev.stop || any_evt)  in_msg <= 1'b0;

      if (ev.start || ev.stop || byte_end) bit_cnt <= '0;
      else if (in_msg && ev.rise)          bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tout_flag    <= 1'b0;
      slv_ext_flag <= 1'b0;
      mst_ext_flag <= 1'b0;
      port_rst     <= 1'b0;
    end else begin
      tout_flag    <= t_evt | (tout_flag    & ~flag_clr);
      slv_ext_flag <= s_evt | (slv_ext_flag & ~flag_clr);
      mst_ext_flag <= m_evt | (mst_ext_flag & ~flag_clr);
      port_rst     <= any_evt;
    end
  end
endmodule

// File: rtl/smbus_lowtime_mon_chk.sv
module smbus_lowtime_mon_chk (
  input logic clk,
  input logic rst,
  input logic flag_clr,
  input logic tout_flag,
  input logic slv_ext_flag,
  input logic mst_ext_flag,
  input logic port_rst
);
  // R9: a flag only drops when a clear was requested
  a_r9_tout_sticky: assert property (@(posedge clk) disable iff (rst)
    (tout_flag && !flag_clr) |=> tout_flag);
  a_r9_slv_sticky: assert property (@(posedge clk) disable iff (rst)
    (slv_ext_flag && !flag_clr) |=> slv_ext_flag);
  a_r9_mst_sticky: assert property (@(posedge clk) disable iff (rst)
    (mst_ext_flag && !flag_clr) |=> mst_ext_flag);
  // R7: a newly raised flag comes with a reset pulse
  a_r7_rise_pulses: assert property (@(posedge clk) disable iff (rst)
    ($rose(tout_flag) || $rose(slv_ext_flag) || $rose(mst_ext_flag)) |-> port_rst);
  // R7: a pulse always leaves some flag standing
  a_r7_pulse_has_flag: assert property (@(posedge clk) disable iff (rst)
    port_rst |-> (tout_flag || slv_ext_flag || mst_ext_flag));
  // R1: everything quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !(port_rst || tout_flag || slv_ext_flag || mst_ext_flag));
endmodule

bind smbus_lowtime_mon smbus_lowtime_mon_chk u_chk (
  .clk(clk), .rst(rst), .flag_clr(flag_clr), .tout_flag(tout_flag),
  .slv_ext_flag(slv_ext_flag), .mst_ext_flag(mst_ext_flag), .port_rst(port_rst)
);

// File: tb/smbus_lowtime_mon_tb.sv
module smbus_lowtime_mon_tb;
  localparam int TOUT = 400;
  localparam int SEXT = 300;
  localparam int MEXT = 120;
  localparam int G    = 20;
  localparam int HI   = 8;
  localparam int BIG  = 1_000_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, clr = 1'b0;
  logic tout_flag, slv_ext_flag, mst_ext_flag, port_rst;

  int checks = 0, errors = 0, pulses = 0;
  int ph_len [64];
  int n_ph;

  always #4 clk = ~clk;

  smbus_lowtime_mon #(.TOUT_CYC(TOUT), .SEXT_CYC(SEXT), .MEXT_CYC(MEXT),
                      .GRACE_CYC(G)) u_dut (
    .clk(clk), .rst(rst), .scl_raw(scl), .sda_raw(sda), .flag_clr(clr),
    .tout_flag(tout_flag), .slv_ext_flag(slv_ext_flag),
    .mst_ext_flag(mst_ext_flag), .port_rst(port_rst)
  );

  always @(negedge clk) if (port_rst) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_phase(input int len);
    scl = 1'b0; wait_cyc(len);
    scl = 1'b1; wait_cyc(HI);
  endtask

  task automatic clear_flags();
    clr = 1'b1; wait_cyc(1); clr = 1'b0; wait_cyc(2);
  endtask

  // Expected flags and pulse count for one message of ph_len[0..n_ph-1]
  task automatic model(output int et, output int es, output int em, output int ep);
    int msg = 0, byt = 0;
    bit live = 1;
    et = 0; es = 0; em = 0; ep = 0;
    for (int i = 0; i < n_ph; i++) begin
      int len = ph_len[i];
      int c  = (len > G) ? len - G : 0;
      int tt = (len >= TOUT) ? TOUT : BIG;
      int ts = BIG, tm = BIG, tmin;
      if (live) begin
        if (msg + c >= SEXT) ts = G + (SEXT - msg);
        if (byt + c >= MEXT) tm = G + (MEXT - byt);
      end
      tmin = tt;
      if (ts < tmin) tmin = ts;
      if (tm < tmin) tmin = tm;
      if (tmin != BIG) begin
        ep++;
        if (tt == tmin) et = 1;
        if (ts == tmin) es = 1;
        if (tm == tmin) em = 1;
        if (tt != BIG && tt > tmin) begin ep++; et = 1; end
        live = 0;
      end else if (live) begin
        msg += c; byt += c;
      end
      if ((i + 1) % 9 == 0) byt = 0;
    end
  endtask

  task automatic run_msg(input string req);
    int et, es, em, ep, p0;
    clear_flags();
    p0 = pulses;
    sda = 1'b0; wait_cyc(5);              // START (R10)
    for (int i = 0; i < n_ph; i++) low_phase(ph_len[i]);
    sda = 1'b1; wait_cyc(10);             // STOP
    model(et, es, em, ep);
    check({req, " tout"}, tout_flag, et);
    check({req, " slv"}, slv_ext_flag, es);
    check({req, " mst"}, mst_ext_flag, em);
    check({req, " pulses"}, pulses - p0, ep);
  endtask

  initial begin
    wait_cyc(5);
    check("R1 tout", tout_flag, 0);
    check("R1 port_rst", port_rst, 0);
    rst = 1'b0; wait_cyc(5);
    check("R1 flags", {tout_flag, slv_ext_flag, mst_ext_flag}, 0);

    // R2 boundary, outside any message (R10)
    scl = 1'b0; wait_cyc(TOUT - 1); scl = 1'b1; wait_cyc(6);
    check("R2 TOUT-1 no flag", tout_flag, 0);
    begin
      int p0 = pulses;
      scl = 1'b0; wait_cyc(TOUT); scl = 1'b1; wait_cyc(6);
      check("R2 TOUT sets flag", tout_flag, 1);
      check("R7 one pulse", pulses - p0, 1);
      check("R10 no ext outside msg", slv_ext_flag | mst_ext_flag, 0);
    end
    wait_cyc(20);
    check("R9 still set", tout_flag, 1);
    clear_flags();
    check("R9 cleared", tout_flag, 0);

    // R3 restart on high
    scl = 1'b0; wait_cyc(TOUT - 1); scl = 1'b1; wait_cyc(1);
    scl = 1'b0; wait_cyc(TOUT - 1); scl = 1'b1; wait_cyc(6);
    check("R3 restart", tout_flag, 0);

    // R4/R6: grace plus byte budget exact and minus one
    n_ph = 1; ph_len[0] = G + MEXT - 1;
    run_msg("R4 under");
    check("R4 mst under", mst_ext_flag, 0);
    ph_len[0] = G + MEXT;
    run_msg("R6 exact");
    check("R6 mst exact", mst_ext_flag, 1);

    // R5: three bytes of 100 units each spend the message budget
    n_ph = 27;
    for (int i = 0; i < 27; i++) ph_len[i] = (i % 9 == 0) ? G + 100 : 10;
    run_msg("R5 three bytes");
    check("R5 slv set", slv_ext_flag, 1);
    check("R6 byte restart", mst_ext_flag, 0);
    n_ph = 18;
    run_msg("R5 restart at START");
    check("R5 slv clear", slv_ext_flag, 0);

    // R8: abandon after byte violation
    n_ph = 5; ph_len[0] = G + MEXT + 50;
    for (int i = 1; i < 5; i++) ph_len[i] = G + 100;
    run_msg("R8 abandon");
    check("R8 no slv", slv_ext_flag, 0);

    // R8/R7: budget then timeout inside one phase
    n_ph = 1; ph_len[0] = TOUT + 10;
    run_msg("R7 two events");

    // random messages
    begin
      void'($urandom(32'h5eed_1234));
      for (int m = 0; m < 60; m++) begin
        n_ph = 1 + ($urandom % 20);
        for (int i = 0; i < n_ph; i++)
          ph_len[i] = ($urandom % 12 == 0) ? 5 + ($urandom % 450)
                                           : 5 + ($urandom % 56);
        run_msg("R5/R6 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule